// File: doc/BRIEF.md
# Daisy-Chain Depth Expansion Slice

This block is one slice of a FIFO that can be chained with identical slices to form a deeper queue. Ownership of the write side and of the read side moves from slice to slice with single-cycle tokens. The slice that holds the write token stores the incoming words. When it fills its last location, it sends a pulse on its write-expansion output, and the next slice in the ring takes the token. The read side passes its token around the same ring in the same way. Seen from the shared write and read buses, a ring of N slices therefore acts as one FIFO of N times the slice depth.

A first-slice strap (`first_n`, driven low on exactly one slice of the ring) decides which slice holds both tokens after reset. All slices share one clock. The slice can also be built with the `MODE` parameter set to stand-alone operation. In that mode it keeps both tokens for good, and its write-expansion output becomes an active-low flag that shows more than half of its locations are in use.

Each direction's ownership is a two-state machine. In `TOK_AWAY` the slice does not hold the token. In `TOK_HELD` it does. The transition `take` (AWAY to HELD) fires on an incoming expansion pulse. The transition `pass` (HELD to AWAY) fires when the slice completes an operation on its last location. When `take` and `pass` fall in the same cycle, the machine stays in AWAY and still emits a pulse. The incoming pulse gives ownership in the same cycle it arrives, so the word that goes with it is not lost.

Top module: `xfifo_slice`

## Requirements
- R1: Out of reset the slice is empty, not full, `rd_vld` is 0, `rd_data` is 0 and `rxo` is 0. In chained mode `wxo_hf` is 0; in stand-alone mode it is 1. In chained mode the slice with `first_n`=0 holds both tokens and every other slice holds neither.
- R2: A write (`wr_en`=1) is stored only by a slice that owns the write token. On every other slice the write has no effect on its contents, its flags or its outputs.
- R3: In chained mode, an accepted write to location DEPTH-1 drives `wxo_hf` to 1 for exactly the next cycle, and the slice gives up the write token.
- R4: In chained mode, a slice that sees `wxi`=1 owns the write token in that same cycle, so a write presented in that cycle is stored in its location 0.
- R5: In chained mode, an accepted read of location DEPTH-1 drives `rxo` to 1 for exactly the next cycle, and the slice gives up the read token.
- R6: In chained mode, a slice that sees `rxi`=1 owns the read token in that same cycle, so a read presented in that cycle returns its location 0.
- R7: A read on a slice without the read token is ignored. That slice's `rd_vld` stays 0 and its `rd_data` stays all zero, and `rd_data` is zero in every cycle where `rd_vld` is 0.
- R8: An accepted read shows the word one clock after the edge that takes it, with `rd_vld`=1. A ring of N slices returns words in exactly the order they were written.
- R9: A write to a full slice is dropped, even if a read happens in the same cycle. A read of an empty slice is dropped, even if a write happens in the same cycle. `full` and `empty` are never 1 together.
- R10: In stand-alone mode, both tokens are always held, the pointers wrap without any pulse, `rxo` stays 0, and `wxo_hf` is 0 exactly when more than DEPTH/2 words are stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by writes and reads |
| rst_n | input | 1 | Asynchronous reset, active low |
| first_n | input | 1 | Strap: 0 on the ring's first slice, 1 on the others |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to write |
| rd_en | input | 1 | Read request |
| wxi | input | 1 | Write token pulse from the previous slice |
| rxi | input | 1 | Read token pulse from the previous slice |
| wxo_hf | output | 1 | Chained: write token pulse to the next slice; stand-alone: half-full flag, active low |
| rxo | output | 1 | Read token pulse to the next slice |
| rd_data | output | WIDTH | Word read, zero when no read took place |
| rd_vld | output | 1 | `rd_data` holds a word read at the last edge |
| full | output | 1 | All locations of this slice are in use |
| empty | output | 1 | No location of this slice is in use |

## Verification
The bench drives a three-slice ring and a stand-alone slice from the same buses. It runs them through fill past capacity, drain past empty, mixed traffic and back-to-back write-with-read, so that tokens cross every slice boundary many times and also wrap from the last slice back to the first.

A grant that took effect one cycle late would drop or misplace the word at each boundary, and the read order would break. A pulse emitted a cycle early, late or twice would show up in the expected one-hot pattern of the expansion outputs. A slice that stored or answered without owning the token would produce a second valid strobe or a corrupted word. Writes when full and reads when empty, each combined with the opposite operation in the same cycle, show whether the flags block correctly. The stand-alone slice is swept across the half-full boundary in both directions.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

    typedef enum logic {
        XF_SOLO    = 1'b0,
        XF_CHAINED = 1'b1
    } xf_mode_e;

    typedef enum logic {
        TOK_AWAY = 1'b0,
        TOK_HELD = 1'b1
    } tok_st_e;

endpackage

// File: rtl/xfifo_token.sv
module xfifo_token
    import xfifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic held_at_reset,
    input  logic xi,
    input  logic pass,
    output logic own,
    output logic xo
);

    tok_st_e state_q;
    tok_st_e state_d;
    logic    xo_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TOK_AWAY: begin
                if (xi && !pass) begin
                    state_d = TOK_HELD;       // take
                end
            end
            TOK_HELD: begin
                if (pass) begin
                    state_d = TOK_AWAY;       // pass
                end
            end
            default: state_d = TOK_AWAY;
        endcase
    end

    // state register and pulse register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= held_at_reset ? TOK_HELD : TOK_AWAY;
            xo_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            xo_q    <= pass;
        end
    end

    // outputs: an arriving pulse grants ownership in its own cycle
    always_comb begin
        own = (state_q == TOK_HELD) || xi;
        xo  = xo_q;
    end

endmodule

// File: rtl/xfifo_store.sv
module xfifo_store #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_go,
    input  logic [WIDTH-1:0]           wr_data,
    input  logic                       rd_go,
    output logic [WIDTH-1:0]           rd_data,
    output logic                       rd_vld,
    output logic [$clog2(DEPTH+1)-1:0] cnt,
    output logic                       full,
    output logic                       empty,
    output logic                       wr_last,
    output logic                       rd_last
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q;

    always_comb begin
        full    = (cnt_q == CW'(DEPTH));
        empty   = (cnt_q == '0);
        wr_last = (wp_q == LAST);
        rd_last = (rp_q == LAST);
        cnt     = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem[wp_q] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q    <= '0;
            rp_q    <= '0;
            cnt_q   <= '0;
            rd_data <= '0;
            rd_vld  <= 1'b0;
        end else begin
            if (wr_go) begin
                wp_q <= wr_last ? '0 : wp_q + 1'b1;
            end
            if (rd_go) begin
                rp_q <= rd_last ? '0 : rp_q + 1'b1;
            end
            if (wr_go && !rd_go) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (rd_go && !wr_go) begin
                cnt_q <= cnt_q - 1'b1;
            end
            rd_data <= rd_go ? mem[rp_q] : '0;
            rd_vld  <= rd_go;
        end
    end

endmodule

// File: rtl/xfifo_slice.sv
module xfifo_slice
    import xfifo_pkg::*;
#(
    parameter xf_mode_e MODE  = XF_CHAINED,
    parameter int       DEPTH = 8,
    parameter int       WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             wxi,
    input  logic             rxi,
    output logic             wxo_hf,
    output logic             rxo,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_vld,
    output logic             full,
    output logic             empty
);

    localparam bit CH = (MODE == XF_CHAINED);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

    logic          held_rst;
    logic          w_xi, r_xi;
    logic          w_own, r_own;
    logic          w_xo, r_xo;
    logic          w_pass, r_pass;
    logic          wr_go, rd_go;
    logic          wr_last, rd_last;
    logic [CW-1:0] cnt;

    // mode straps: stand-alone holds both tokens and never passes them
    always_comb begin
        held_rst = CH ? !first_n : 1'b1;
        w_xi     = CH ? wxi : 1'b0;
        r_xi     = CH ? rxi : 1'b0;
        wr_go    = wr_en && w_own && !full;
        rd_go    = rd_en && r_own && !empty;
        w_pass   = CH && wr_go && wr_last;
        r_pass   = CH && rd_go && rd_last;
    end

    xfifo_token u_wtok (
        .clk           (clk),
        .rst_n         (rst_n),
        .held_at_reset (held_rst),
        .xi            (w_xi),
        .pass          (w_pass),
        .own           (w_own),
        .xo            (w_xo)
    );

    xfifo_token u_rtok (
        .clk           (clk),
        .rst_n         (rst_n),
        .held_at_reset (held_rst),
        .xi            (r_xi),
        .pass          (r_pass),
        .own           (r_own),
        .xo            (r_xo)
    );

    xfifo_store #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_go),
        .wr_data (wr_data),
        .rd_go   (rd_go),
        .rd_data (rd_data),
        .rd_vld  (rd_vld),
        .cnt     (cnt),
        .full    (full),
        .empty   (empty),
        .wr_last (wr_last),
        .rd_last (rd_last)
    );

    always_comb begin
        wxo_hf = CH ? w_xo : !(cnt > HALF);
        rxo    = r_xo;
    end

endmodule

// File: rtl/xfifo_slice_chk.sv
module xfifo_slice_chk
    import xfifo_pkg::*;
#(
    parameter xf_mode_e MODE  = XF_CHAINED,
    parameter int       WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic             wxo_hf,
    input logic             rxo,
    input logic [WIDTH-1:0] rd_data,
    input logic             rd_vld,
    input logic             full,
    input logic             empty
);

    localparam bit CH = (MODE == XF_CHAINED);

    p_wxo_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (CH && wxo_hf) |=> !wxo_hf);

    p_rxo_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rxo |=> !rxo);

    p_idle_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_vld |-> (rd_data == '0));

    p_read_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> $past(rd_en));

    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> !rd_vld);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en) |=> full);

    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    p_solo_hf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!CH && !wxo_hf) |-> !empty);

    p_solo_rxo_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !CH |-> !rxo);

endmodule

bind xfifo_slice xfifo_slice_chk #(
    .MODE  (MODE),
    .WIDTH (WIDTH)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .wxo_hf  (wxo_hf),
    .rxo     (rxo),
    .rd_data (rd_data),
    .rd_vld  (rd_vld),
    .full    (full),
    .empty   (empty)
);

// File: tb/sim_xfifo_slice.sv
module sim_xfifo_slice;
    import xfifo_pkg::*;

    localparam int CLK_P = 10;
    localparam int D     = 4;
    localparam int W     = 8;
    localparam int N     = 3;
    localparam int CAP   = N * D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [W-1:0] wr_data = '0;

    logic [N-1:0] c_wxo, c_rxo, c_vld, c_full, c_empty;
    logic [W-1:0] c_dat [N];
    logic [W-1:0] c_or;
    logic s_hf, s_rxo, s_vld, s_full, s_empty;
    logic [W-1:0] s_dat;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    for (genvar i = 0; i < N; i++) begin : g_ring
        xfifo_slice #(.MODE(XF_CHAINED), .DEPTH(D), .WIDTH(W)) u_ring (
            .clk(clk), .rst_n(rst_n), .first_n(i != 0),
            .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
            .wxi(c_wxo[(i+N-1)%N]), .rxi(c_rxo[(i+N-1)%N]),
            .wxo_hf(c_wxo[i]), .rxo(c_rxo[i]),
            .rd_data(c_dat[i]), .rd_vld(c_vld[i]),
            .full(c_full[i]), .empty(c_empty[i])
        );
    end

    xfifo_slice #(.MODE(XF_SOLO), .DEPTH(D), .WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .first_n(1'b0),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .wxi(1'b0), .rxi(1'b0),
        .wxo_hf(s_hf), .rxo(s_rxo),
        .rd_data(s_dat), .rd_vld(s_vld),
        .full(s_full), .empty(s_empty)
    );

    always_comb begin
        c_or = '0;
        for (int i = 0; i < N; i++) c_or = c_or | c_dat[i];
    end

    // reference model state
    logic [W-1:0] cq [CAP];
    logic [W-1:0] sq [D];
    int chead = 0, ccnt = 0, wtot = 0, rtot = 0;
    int shead = 0, scnt = 0;
    logic [N-1:0] e_vld = '0, e_wxo = '0, e_rxo = '0;
    logic [W-1:0] e_dat = '0, es_dat = '0;
    logic es_vld = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // one cycle: check results of the previous edge, then drive the next
    task automatic cycle(input logic wr, input logic rd);
        logic wacc, racc, swacc, sracc;
        @(negedge clk);
        chk("R2 R7 R8 ring rd_vld", 32'(c_vld), 32'(e_vld));
        chk("R8 ring rd_data", 32'(c_or), 32'(e_dat));
        chk("R2 R3 R4 ring wxo", 32'(c_wxo), 32'(e_wxo));
        chk("R5 R6 ring rxo", 32'(c_rxo), 32'(e_rxo));
        chk("R10 solo rd_vld", 32'(s_vld), 32'(es_vld));
        chk("R10 solo rd_data", 32'(s_dat), 32'(es_dat));
        chk("R9 solo full", 32'(s_full), 32'(scnt == D));
        chk("R9 solo empty", 32'(s_empty), 32'(scnt == 0));
        chk("R10 solo half flag", 32'(s_hf), 32'(!(scnt > D/2)));
        chk("R10 solo rxo", 32'(s_rxo), 32'd0);

        step_lfsr();
        wr_en   = wr;
        rd_en   = rd;
        wr_data = lfsr[7:0];

        wacc = wr && (ccnt < CAP);
        racc = rd && (ccnt > 0);
        e_vld = '0; e_dat = '0; e_wxo = '0; e_rxo = '0;
        if (racc) begin
            e_vld[(rtot / D) % N] = 1'b1;
            e_dat = cq[chead];
            if (rtot % D == D - 1) e_rxo[(rtot / D) % N] = 1'b1;
            chead = (chead + 1) % CAP;
            rtot++;
            ccnt--;
        end
        if (wacc) begin
            cq[(chead + ccnt) % CAP] = wr_data;
            if (wtot % D == D - 1) e_wxo[(wtot / D) % N] = 1'b1;
            wtot++;
            ccnt++;
        end

        swacc = wr && (scnt < D);
        sracc = rd && (scnt > 0);
        es_vld = sracc;
        es_dat = '0;
        if (sracc) begin
            es_dat = sq[shead];
            shead = (shead + 1) % D;
            scnt--;
        end
        if (swacc) begin
            sq[(shead + scnt) % D] = wr_data;
            scnt++;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state of every slice
        chk("R1 ring empty", 32'(c_empty), 32'((1 << N) - 1));
        chk("R1 ring full", 32'(c_full), 32'd0);
        chk("R1 ring wxo", 32'(c_wxo), 32'd0);
        chk("R1 ring rxo", 32'(c_rxo), 32'd0);
        chk("R1 ring rd_vld", 32'(c_vld), 32'd0);
        chk("R1 ring rd_data", 32'(c_or), 32'd0);
        chk("R1 solo half flag", 32'(s_hf), 32'd1);
        chk("R1 solo empty", 32'(s_empty), 32'd1);

        // fill beyond capacity (R9 overflow)
        for (int k = 0; k < CAP + 6; k++) cycle(1'b1, 1'b0);
        // full with simultaneous read and write
        for (int k = 0; k < 4; k++) cycle(1'b1, 1'b1);
        // drain beyond empty (R9 underflow)
        for (int k = 0; k < CAP + 6; k++) cycle(1'b0, 1'b1);
        // empty with simultaneous write and read
        for (int k = 0; k < 4; k++) cycle(1'b1, 1'b1);
        // mixed traffic
        for (int k = 0; k < 600; k++) cycle(lfsr[3], lfsr[9]);
        // write heavy
        for (int k = 0; k < 300; k++) cycle(lfsr[2] | lfsr[5], lfsr[7] & lfsr[11]);
        // read heavy
        for (int k = 0; k < 300; k++) cycle(lfsr[2] & lfsr[5], lfsr[7] | lfsr[11]);
        // back to back, tokens circle the ring repeatedly
        for (int k = 0; k < 100; k++) cycle(1'b1, 1'b1);
        for (int k = 0; k < CAP + 4; k++) cycle(1'b0, 1'b1);
        cycle(1'b0, 1'b0);
        cycle(1'b0, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule